// File: doc/BRIEF.md
# I2C SCL Timebase Generator

This block turns a fast module clock into the timing strokes that an I2C master sequencer needs to shape SCL. A two-stage divider does the work. The first stage is a prescaler that divides the module clock by a small programmable factor and emits a one-cycle interface clock enable. The second stage counts those enables through one SCL period and splits it into four quarters. At the start of each quarter it raises a tick strobe that carries a quarter code, so the sequencer knows when to pull SCL low, when to change SDA, when to release SCL and when to sample SDA.

Both divisors come from one 8-bit control word. The prescale field occupies bits [1:0], and the interface clock runs at the module clock divided by (field + 1). The period field occupies bits [7:2], and one SCL period lasts (8 × field + 20) interface clock cycles. Software chooses the field values. It must keep the interface clock below 20 MHz, and it works out the best setting for a target bit rate itself. The word is sampled only at a period boundary, so rewriting it never produces a truncated SCL pulse. A slave that stretches the clock is honoured: while SCL should be high but reads low, the high-phase count waits.

The interface consists only of plain control and status pins. No data stream passes through the block, so no valid/ready handshake applies.

Top module: `scl_timebase`

## Requirements
- R1: While `rst_n` is low, `iclk_en`, `tick` and `scl_level` are all 0, whatever `run` is.
- R2: `run` is registered. One cycle after `run` is sampled low, `iclk_en`, `tick` and `scl_level` stay 0 until `run` is sampled high again. Restarting always begins a fresh period.
- R3: While running with prescale field `ccr[1:0]` = D, `iclk_en` pulses once every D+1 module clocks. Each SCL period contains exactly 8×S+20 of these pulses, where S = `ccr[7:2]`.
- R4: The first tick after a start carries code 0. It appears D+1 module clocks after the clock edge that first samples `run` high.
- R5: With a constant control word, consecutive code-0 ticks are (8×S+20)×(D+1) module clocks apart.
- R6: Each period emits exactly four ticks, coded in order 0 (SCL falls), 1 (data setup, middle of low phase), 2 (SCL released), 3 (sample point, middle of high phase). Each tick coincides with an `iclk_en` pulse. With the default constants the four quarters are equal, each (2×S+5)×(D+1) module clocks long. If a period count is odd, the extra cycle goes to the low half.
- R7: `scl_level` is 0 during quarters 0 and 1 and 1 during quarters 2 and 3. It reads 1 in the cycle of a code-2 tick and 0 in the cycle of a code-0 tick.
- R8: `scl_in` passes through one register. While the period is in quarter 2 or 3 and the registered `scl_in` is 0, the quarter count holds. A code-2 tick that was held back appears in the module clock after `scl_in` has been registered high again.
- R9: A low `scl_in` during quarters 0 and 1 has no effect on tick timing.
- R10: `ccr` is taken only at the final interface cycle of a period, or at any cycle while stopped. A value present in that final cycle governs the next period. A value written one cycle later waits a full period. The first code-0 tick of a period follows the last `iclk_en` of the previous period by (new D)+1 module clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables the divider; registered before use |
| ccr | input | 8 | Control word: [1:0] prescale, [7:2] period field |
| scl_in | input | 1 | SCL as read back from the bus, already synchronised |
| iclk_en | output | 1 | One-cycle interface clock enable |
| scl_level | output | 1 | Requested SCL level (1 = release, 0 = drive low) |
| tick | output | 1 | Quarter-start strobe |
| tick_code | output | 2 | Quarter code of the current tick (0..3) |

## Verification
Two events can land in the same module clock: a write to the control word, and the final interface cycle of a period, where the control word is sampled. The bench counts clocks from a code-3 tick to reach the exact last cycle of a period and rewrites the word there. It then rewrites the word again in the cycle of the following code-0 tick. The first write must shape the very next period. The second must leave that period alone and take effect one period later, and the distance between ticks is compared against the formula. A clock stretch that starts and ends inside the high phase is checked the same way, by counting clocks to the delayed tick.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;

  typedef enum logic [1:0] {
    TK_FALL   = 2'd0,
    TK_SETUP  = 2'd1,
    TK_RISE   = 2'd2,
    TK_SAMPLE = 2'd3
  } tick_code_e;

  // Length in interface cycles of quarter q for a period field value.
  // An odd half or odd period hands its spare cycle to the earlier part,
  // so the low half and the first quarter of each half are never shorter.
  function automatic int quarter_len(input int field, input int step,
                                     input int base, input logic [1:0] q);
    int total;
    int lo_half;
    int hi_half;
    total   = field * step + base;
    hi_half = total / 2;
    lo_half = total - hi_half;
    case (q)
      2'd0:    return lo_half - lo_half / 2;
      2'd1:    return lo_half / 2;
      2'd2:    return hi_half - hi_half / 2;
      default: return hi_half / 2;
    endcase
  endfunction

endpackage

// File: rtl/scl_prescale.sv
`timescale 1ns/1ps
module scl_prescale #(
  parameter int CDF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CDF_W-1:0] div,
  output logic             en
);

  logic [CDF_W-1:0] cnt;

  assign en = go && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!go || en) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CDF_W'(1);
    end
  end

endmodule

// File: rtl/scl_phase_seq.sv
`timescale 1ns/1ps
module scl_phase_seq import scl_div_pkg::*; #(
  parameter int SCGD_W      = 6,
  parameter int PERIOD_STEP = 8,
  parameter int PERIOD_BASE = 20,
  parameter int QW          = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              step,
  input  logic              scl_high,
  input  logic [SCGD_W-1:0] field,
  output logic [1:0]        phase,
  output logic [QW-1:0]     qcnt,
  output logic              stall,
  output logic              tick,
  output logic              wrap
);

  logic [QW-1:0] qlast;
  logic          adv;
  logic          at_end;

  always_comb begin
    qlast = QW'(quarter_len(int'(field), PERIOD_STEP, PERIOD_BASE, phase) - 1);
  end

  // High phase waits for the bus to actually read high.
  assign stall  = go && phase[1] && !scl_high;
  assign adv    = step && !stall;
  assign at_end = (qcnt == qlast);
  assign tick   = adv && (qcnt == '0);
  assign wrap   = adv && at_end && (phase == 2'(TK_SAMPLE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 2'(TK_FALL);
      qcnt  <= '0;
    end else if (!go) begin
      phase <= 2'(TK_FALL);
      qcnt  <= '0;
    end else if (adv) begin
      if (at_end) begin
        qcnt  <= '0;
        phase <= phase + 2'd1;
      end else begin
        qcnt  <= qcnt + QW'(1);
      end
    end
  end

endmodule

// File: rtl/scl_timebase.sv
`timescale 1ns/1ps
module scl_timebase #(
  parameter int CDF_W       = 2,
  parameter int SCGD_W      = 6,
  parameter int PERIOD_STEP = 8,
  parameter int PERIOD_BASE = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [CDF_W+SCGD_W-1:0] ccr,
  input  logic                    scl_in,
  output logic                    iclk_en,
  output logic                    scl_level,
  output logic                    tick,
  output logic [1:0]              tick_code
);

  localparam int CCR_W = CDF_W + SCGD_W;
  localparam int MAX_N = ((1 << SCGD_W) - 1) * PERIOD_STEP + PERIOD_BASE;
  localparam int QW    = $clog2(MAX_N + 1);

  logic              active;
  logic              go;
  logic              scl_q;
  logic [CDF_W-1:0]  cdf_q;
  logic [SCGD_W-1:0] scgd_q;
  logic [1:0]        phase;
  logic [QW-1:0]     qcnt;
  logic              stall;
  logic              wrap;

  assign go = run && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      scl_q  <= 1'b1;
      cdf_q  <= '0;
      scgd_q <= '0;
    end else begin
      active <= run;
      scl_q  <= scl_in;
      // Configuration is only taken between periods.
      if (!go || wrap) begin
        cdf_q  <= ccr[CDF_W-1:0];
        scgd_q <= ccr[CCR_W-1:CDF_W];
      end
    end
  end

  scl_prescale #(
    .CDF_W (CDF_W)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .div   (cdf_q),
    .en    (iclk_en)
  );

  scl_phase_seq #(
    .SCGD_W      (SCGD_W),
    .PERIOD_STEP (PERIOD_STEP),
    .PERIOD_BASE (PERIOD_BASE),
    .QW          (QW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .step     (iclk_en),
    .scl_high (scl_q),
    .field    (scgd_q),
    .phase    (phase),
    .qcnt     (qcnt),
    .stall    (stall),
    .tick     (tick),
    .wrap     (wrap)
  );

  assign scl_level = go && phase[1];
  assign tick_code = phase;

endmodule

// File: rtl/scl_timebase_chk.sv
`timescale 1ns/1ps
module scl_timebase_chk #(
  parameter int CDF_W  = 2,
  parameter int SCGD_W = 6,
  parameter int QW     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              go,
  input logic              iclk_en,
  input logic              tick,
  input logic [1:0]        tick_code,
  input logic              scl_level,
  input logic              stall,
  input logic              wrap,
  input logic [1:0]        phase,
  input logic [QW-1:0]     qcnt,
  input logic [CDF_W-1:0]  cdf_q,
  input logic [SCGD_W-1:0] scgd_q
);

  logic       seen;
  logic [1:0] last_code;

  always_ff @(posedge clk) begin
    if (!rst_n || !go) begin
      seen      <= 1'b0;
      last_code <= 2'd0;
    end else if (tick) begin
      seen      <= 1'b1;
      last_code <= tick_code;
    end
  end

  a_r2_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!iclk_en && !tick && !scl_level));

  a_r3_en_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (iclk_en && (cdf_q != '0) && !wrap) |=> !iclk_en);

  a_r6_tick_on_en: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> iclk_en);

  a_r6_code_order: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> (tick_code == last_code + 2'd1));

  a_r7_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tick_code == 2'd2) |-> scl_level);

  a_r7_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tick_code == 2'd0) |-> !scl_level);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(qcnt) && $stable(phase)));

  a_r10_cfg_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wrap) |=> ($stable(cdf_q) && $stable(scgd_q)));

endmodule

bind scl_timebase scl_timebase_chk #(
  .CDF_W  (CDF_W),
  .SCGD_W (SCGD_W),
  .QW     (QW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .go        (go),
  .iclk_en   (iclk_en),
  .tick      (tick),
  .tick_code (tick_code),
  .scl_level (scl_level),
  .stall     (stall),
  .wrap      (wrap),
  .phase     (phase),
  .qcnt      (qcnt),
  .cdf_q     (cdf_q),
  .scgd_q    (scgd_q)
);

// File: tb/sim_scl_timebase.sv
`timescale 1ns/1ps
module sim_scl_timebase;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;
  // {control word, expected period in module clocks}
  localparam int VTAB [NVEC][2] = '{
    '{8'h00, 20},
    '{8'h01, 40},
    '{8'h0C, 44},
    '{8'h0B, 144},
    '{8'hFA, 1548},
    '{8'hFC, 524}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] ccr = 8'h00;
  logic       ext_low = 1'b0;
  logic       scl_in;
  logic       iclk_en;
  logic       scl_level;
  logic       tick;
  logic [1:0] tick_code;

  int cyc = 0;
  int en_cnt = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign scl_in = !ext_low;

  always #(CLK_PERIOD/2) clk = !clk;

  scl_timebase u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ccr       (ccr),
    .scl_in    (scl_in),
    .iclk_en   (iclk_en),
    .scl_level (scl_level),
    .tick      (tick),
    .tick_code (tick_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (iclk_en) en_cnt++;
  endtask

  task automatic tick_wait(input int code, output int at);
    int n;
    n = 0;
    at = -1;
    forever begin
      step();
      n++;
      if (tick && tick_code == code[1:0]) begin
        at = cyc;
        break;
      end
      if (n > 6000) begin
        chk("tick timeout", n, 0);
        break;
      end
    end
  endtask

  task automatic restart(input logic [7:0] word, output int start_cyc);
    run = 1'b0;
    ccr = word;
    repeat (3) step();
    start_cyc = cyc;
    run = 1'b1;
  endtask

  initial begin
    int c, t0, t1, t2, t3, t4, e0, a, b, rel, bad;

    // R1: outputs quiet in reset even with run high
    run = 1'b1;
    bad = 0;
    repeat (5) begin
      step();
      if (iclk_en || tick || scl_level) bad++;
    end
    chk("R1 reset quiet", bad, 0);
    run = 1'b0;
    rst_n = 1'b1;
    step();

    // Table walk: R3, R4, R5, R6, R7
    for (int i = 0; i < NVEC; i++) begin
      int d, per, q;
      d   = VTAB[i][0] & 3;
      per = VTAB[i][1];
      q   = per / 4;
      restart(8'(VTAB[i][0]), c);
      tick_wait(0, t0);
      chk("R4 first tick delay", t0 - c, d + 1);
      chk("R7 low at code 0", int'(scl_level), 0);
      e0 = en_cnt;
      tick_wait(1, t1);
      chk("R6 quarter 0 length", t1 - t0, q);
      tick_wait(2, t2);
      chk("R6 quarter 1 length", t2 - t1, q);
      chk("R7 high at code 2", int'(scl_level), 1);
      tick_wait(3, t3);
      chk("R6 quarter 2 length", t3 - t2, q);
      tick_wait(0, t4);
      chk("R5 period length", t4 - t0, per);
      chk("R3 enables per period", en_cnt - e0, per / (d + 1));
    end

    // R2: stopping silences every output
    run = 1'b0;
    step();
    bad = 0;
    repeat (30) begin
      step();
      if (iclk_en || tick || scl_level) bad++;
    end
    chk("R2 stopped quiet", bad, 0);

    // R9: low SCL during the low phase changes nothing (quarter 5 clocks)
    restart(8'h00, c);
    tick_wait(0, t0);
    ext_low = 1'b1;
    tick_wait(1, t1);
    chk("R9 low-phase quarter", t1 - t0, 5);
    ext_low = 1'b0;
    tick_wait(2, t2);
    chk("R9 second low quarter", t2 - t1, 5);

    // R8: stretch across the start of the high phase
    tick_wait(1, t1);
    ext_low = 1'b1;
    repeat (10) step();
    chk("R8 level high while stretched", int'(scl_level), 1);
    ext_low = 1'b0;
    rel = cyc;
    tick_wait(2, t2);
    chk("R8 rise tick after release", t2 - rel, 1);
    tick_wait(3, t3);
    chk("R8 quarter after stretch", t3 - t2, 5);
    // R8: stretch inside the last quarter (7 held clocks)
    ext_low = 1'b1;
    repeat (7) step();
    ext_low = 1'b0;
    tick_wait(0, t4);
    chk("R8 held sample quarter", t4 - t3, 12);

    // R10: write in the final cycle of a period vs one cycle later
    restart(8'h04, c);
    tick_wait(3, t3);
    repeat (6) step();
    ccr = 8'h00;
    tick_wait(0, a);
    chk("R10 current period kept", a - t3, 7);
    ccr = 8'h05;
    tick_wait(0, b);
    chk("R10 last-cycle write applied", b - a, 21);
    tick_wait(0, t4);
    chk("R10 late write deferred", t4 - b, 56);

    run = 1'b0;
    step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got %0d cycles expected fewer", WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule